// File: doc/BRIEF.md
# Arithmetic Coder Range Renormalizer

This block restores the interval register of a multiplication-free, multi-symbol arithmetic coder after each symbol has narrowed it. The 16-bit range is read as a fixed-point value with weight one on its top bit. The block moves it back into the window [0.75, 1.5), which is 0x6000 up to but not including 0xC000. To get there it first finds the most significant set bit with a priority encoder and shifts left until that bit is on top, which puts the value in [1, 2). It then checks the bit just below the top: when that bit is set it takes back one position of the shift. The code register moves left by the same net amount.

In encoder mode the code register is 64 bits wide. Its upper 48 bits form a carry guard that counts the carry out of the 16-bit low-part adder. This keeps carries from rippling into bits that have already been emitted. The bits that leave the top of the code register are handed to the output buffer together with their count. In decoder mode only 16 bits of code are kept and there is no guard. The vacated low bits are filled from the incoming code stream, and the block reports how many stream bits it used.

The block takes one input set per clock when `in_valid` is high and presents the registered result on the next clock.

Top module: `rn_renorm`

## Requirements
- R1: After reset, `out_valid`, `range_out`, `code_out`, `shift_cnt`, `enc_bits`, `enc_nbits`, `dec_nbits` and `range_err` are all zero.
- R2: A cycle with `in_valid` high produces `out_valid` high one clock later, with the results for those inputs. A cycle with `in_valid` low gives `out_valid` low on the next clock and leaves every other output unchanged, whatever the other inputs carry.
- R3: For every legal range input (1 to 0xBFFF), `range_out` lies in [0x6000, 0xC000).
- R4: For a legal range, `shift_cnt` equals the number of leading zeros of `range_in`, less one when the bit just below the leading one is 1, and `range_out` equals `range_in` shifted left by `shift_cnt`.
- R5: In encoder mode (`dec_mode` = 0), bits 63:16 of `code_in` are first incremented by `carry_in`, wrapping modulo 2^48. `code_out` is then that adjusted value shifted left by `shift_cnt`, with zeros entering at the bottom.
- R6: In encoder mode, `enc_bits` holds the top `shift_cnt` bits of the adjusted code register, right-aligned so that the first bit out sits at bit position `shift_cnt`-1. `enc_nbits` equals `shift_cnt` and `dec_nbits` is zero.
- R7: In decoder mode (`dec_mode` = 1), `code_out[15:0]` is `code_in[15:0]` shifted left by `shift_cnt`, with the vacated low bits filled from the top `shift_cnt` bits of `stream_in`, MSB first. `code_out[63:16]` is zero, `dec_nbits` equals `shift_cnt`, `enc_nbits` and `enc_bits` are zero, and `carry_in` has no effect.
- R8: A range input of zero, or of 0xC000 and above, sets `range_err`. In that case `shift_cnt` and both counts are zero and `range_out` equals `range_in`. `code_out` equals `code_in` in encoder mode, with `carry_in` ignored, and `code_in[15:0]` zero-extended in decoder mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input set is present this cycle |
| dec_mode | input | 1 | 0 = encoder, 1 = decoder |
| range_in | input | 16 | Unnormalized range |
| code_in | input | 64 | Code register (decoder uses bits 15:0) |
| carry_in | input | 1 | Carry out of the low-part adder (encoder) |
| stream_in | input | 16 | Next incoming code-stream bits, MSB first (decoder) |
| out_valid | output | 1 | Result registers hold a new result |
| range_out | output | 16 | Normalized range |
| code_out | output | 64 | Shifted code register |
| shift_cnt | output | 5 | Net left-shift applied |
| enc_bits | output | 16 | Bits shifted out of the code register, right-aligned |
| enc_nbits | output | 5 | Number of valid bits in `enc_bits` |
| dec_nbits | output | 5 | Number of stream bits consumed |
| range_err | output | 1 | Range input outside the legal domain |

## Verification
The range input is swept so that the leading one takes every position, each with the bit below it both clear and set. This separates the plain leading-one shift from the case that takes one position back. It also covers the window edges 0x6000, 0xBFFF, 0x5FFF, 0x0001 and 0x0003. Both modes get the same ranges with random code and stream words, so shifted-out bits and shifted-in stream bits are compared against an independent model. A guard of all ones with a carry tests the wrap of the guard counter. The illegal ranges 0, 0xC000 and 0xFFFF, along with idle cycles that carry changing inputs, show that nothing moves when it must not.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic {
        RN_ENC = 1'b0,
        RN_DEC = 1'b1
    } rn_mode_e;
endpackage

// File: rtl/rn_lead_one.sv
// Priority encoder: leading-zero count of val; none is set when val is zero.
module rn_lead_one #(
    parameter int W  = 16,
    parameter int SW = $clog2(W) + 1
) (
    input  logic [W-1:0]  val,
    output logic [SW-1:0] lz,
    output logic          none
);
    always_comb begin
        lz   = SW'(W);
        none = 1'b1;
        // Higher bits are visited later and so take priority.
        for (int i = 0; i < W; i++) begin
            if (val[i]) begin
                lz   = SW'(W - 1 - i);
                none = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rn_enc_path.sv
// Encoder code path: guard counter absorbs the carry, then the whole register shifts left.
module rn_enc_path #(
    parameter int RANGE_W = 16,
    parameter int CODE_W  = 64,
    parameter int SW      = $clog2(RANGE_W) + 1
) (
    input  logic [CODE_W-1:0]  code_in,
    input  logic               carry,
    input  logic [SW-1:0]      shift,
    output logic [CODE_W-1:0]  code_out,
    output logic [RANGE_W-1:0] bits_out
);
    localparam int GUARD_W = CODE_W - RANGE_W;
    localparam int WIDE_W  = CODE_W + RANGE_W;

    logic [GUARD_W-1:0] guard_inc;
    logic [CODE_W-1:0]  adj;
    logic [WIDE_W-1:0]  wide;

    always_comb begin
        guard_inc = code_in[CODE_W-1:RANGE_W] + GUARD_W'(carry);
        adj       = {guard_inc, code_in[RANGE_W-1:0]};
        wide      = {{RANGE_W{1'b0}}, adj} << shift;
        code_out  = wide[CODE_W-1:0];
        bits_out  = wide[WIDE_W-1:CODE_W];
    end
endmodule

// File: rtl/rn_dec_path.sv
// Decoder code path: 16-bit code register refilled from the incoming stream.
module rn_dec_path #(
    parameter int RANGE_W = 16,
    parameter int SW      = $clog2(RANGE_W) + 1
) (
    input  logic [RANGE_W-1:0] code_in,
    input  logic [RANGE_W-1:0] stream,
    input  logic [SW-1:0]      shift,
    output logic [RANGE_W-1:0] code_out
);
    logic [2*RANGE_W-1:0] joined;

    always_comb begin
        joined   = {code_in, stream} << shift;
        code_out = joined[2*RANGE_W-1:RANGE_W];
    end
endmodule

// File: rtl/rn_renorm.sv
module rn_renorm #(
    parameter int RANGE_W = 16,
    parameter int CODE_W  = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          dec_mode,
    input  logic [RANGE_W-1:0]            range_in,
    input  logic [CODE_W-1:0]             code_in,
    input  logic                          carry_in,
    input  logic [RANGE_W-1:0]            stream_in,
    output logic                          out_valid,
    output logic [RANGE_W-1:0]            range_out,
    output logic [CODE_W-1:0]             code_out,
    output logic [$clog2(RANGE_W):0]      shift_cnt,
    output logic [RANGE_W-1:0]            enc_bits,
    output logic [$clog2(RANGE_W):0]      enc_nbits,
    output logic [$clog2(RANGE_W):0]      dec_nbits,
    output logic                          range_err
);
    import rn_pkg::*;

    localparam int SW      = $clog2(RANGE_W) + 1;
    localparam int GUARD_W = CODE_W - RANGE_W;

    typedef struct packed {
        logic               valid;
        logic [RANGE_W-1:0] range;
        logic [CODE_W-1:0]  code;
        logic [SW-1:0]      shift;
        logic [RANGE_W-1:0] bits;
        logic [SW-1:0]      enc_n;
        logic [SW-1:0]      dec_n;
        logic               err;
    } rn_state_t;

    rn_state_t st_d, st_q;
    rn_mode_e  mode;

    logic [SW-1:0]      lz;
    logic               none;
    logic [RANGE_W-1:0] lead_al;
    logic               below;
    logic               bad;
    logic [SW-1:0]      net;
    logic [RANGE_W-1:0] range_norm;
    logic [CODE_W-1:0]  enc_code;
    logic [RANGE_W-1:0] enc_out;
    logic [RANGE_W-1:0] dec_code;

    assign mode = rn_mode_e'(dec_mode);

    rn_lead_one #(.W(RANGE_W), .SW(SW)) u_lead (
        .val  (range_in),
        .lz   (lz),
        .none (none)
    );

    // Step one aligns the leading one; step two looks at the bit beneath it.
    always_comb begin
        lead_al    = range_in << lz;
        below      = lead_al[RANGE_W-2];
        bad        = none | ((lz == '0) & below);
        net        = bad ? '0 : (lz - SW'(below));
        range_norm = bad ? range_in : (range_in << net);
    end

    rn_enc_path #(.RANGE_W(RANGE_W), .CODE_W(CODE_W), .SW(SW)) u_enc (
        .code_in  (code_in),
        .carry    (carry_in & ~bad),
        .shift    (net),
        .code_out (enc_code),
        .bits_out (enc_out)
    );

    rn_dec_path #(.RANGE_W(RANGE_W), .SW(SW)) u_dec (
        .code_in  (code_in[RANGE_W-1:0]),
        .stream   (stream_in),
        .shift    (net),
        .code_out (dec_code)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.range = range_norm;
            st_d.shift = net;
            st_d.err   = bad;
            if (mode == RN_DEC) begin
                st_d.code  = {{GUARD_W{1'b0}}, dec_code};
                st_d.bits  = '0;
                st_d.enc_n = '0;
                st_d.dec_n = net;
            end else begin
                st_d.code  = enc_code;
                st_d.bits  = enc_out;
                st_d.enc_n = net;
                st_d.dec_n = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign range_out = st_q.range;
    assign code_out  = st_q.code;
    assign shift_cnt = st_q.shift;
    assign enc_bits  = st_q.bits;
    assign enc_nbits = st_q.enc_n;
    assign dec_nbits = st_q.dec_n;
    assign range_err = st_q.err;
endmodule

// File: rtl/rn_renorm_chk.sv
module rn_renorm_chk #(
    parameter int RANGE_W = 16,
    parameter int CODE_W  = 64
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     dec_mode,
    input logic                     out_valid,
    input logic [RANGE_W-1:0]       range_out,
    input logic [CODE_W-1:0]        code_out,
    input logic [$clog2(RANGE_W):0] shift_cnt,
    input logic [$clog2(RANGE_W):0] enc_nbits,
    input logic [$clog2(RANGE_W):0] dec_nbits,
    input logic                     range_err
);
    localparam int SW = $clog2(RANGE_W) + 1;
    localparam logic [RANGE_W-1:0] WIN_LO = RANGE_W'(3) << (RANGE_W - 3);
    localparam logic [RANGE_W-1:0] WIN_HI = RANGE_W'(3) << (RANGE_W - 2);

    // R2: a presented input yields a result on the next clock
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: idle cycles leave the results untouched
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(range_out) && $stable(code_out)));

    // R3: legal results land in the target window
    p_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !range_err) |-> (range_out >= WIN_LO && range_out < WIN_HI));

    // R4: net shift stays below the register width
    p_shift_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !range_err) |-> (shift_cnt < SW'(RANGE_W)));

    // R6: encoder reports emitted bits, not consumed ones
    p_enc_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(dec_mode)) |-> (enc_nbits == shift_cnt && dec_nbits == '0));

    // R7: decoder keeps no guard and reports consumed bits
    p_dec_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(dec_mode)) |->
        (code_out[CODE_W-1:RANGE_W] == '0 && dec_nbits == shift_cnt && enc_nbits == '0));

    // R8: an illegal range shifts nothing
    p_err_noshift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && range_err) |-> (shift_cnt == '0 && enc_nbits == '0 && dec_nbits == '0));
endmodule

bind rn_renorm rn_renorm_chk #(.RANGE_W(RANGE_W), .CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .dec_mode  (dec_mode),
    .out_valid (out_valid),
    .range_out (range_out),
    .code_out  (code_out),
    .shift_cnt (shift_cnt),
    .enc_nbits (enc_nbits),
    .dec_nbits (dec_nbits),
    .range_err (range_err)
);

// File: tb/rn_renorm_tb.sv
`timescale 1ns/1ps
module rn_renorm_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        dec_mode = 1'b0;
    logic [15:0] range_in = '0;
    logic [63:0] code_in = '0;
    logic        carry_in = 1'b0;
    logic [15:0] stream_in = '0;
    logic        out_valid;
    logic [15:0] range_out;
    logic [63:0] code_out;
    logic [4:0]  shift_cnt;
    logic [15:0] enc_bits;
    logic [4:0]  enc_nbits;
    logic [4:0]  dec_nbits;
    logic        range_err;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [15:0] e_range;
    logic [63:0] e_code;
    logic [4:0]  e_shift;
    logic [15:0] e_bits;
    logic [4:0]  e_en;
    logic [4:0]  e_dn;
    logic        e_err;

    always #10 clk = ~clk;

    rn_renorm u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dec_mode(dec_mode),
        .range_in(range_in), .code_in(code_in), .carry_in(carry_in), .stream_in(stream_in),
        .out_valid(out_valid), .range_out(range_out), .code_out(code_out),
        .shift_cnt(shift_cnt), .enc_bits(enc_bits), .enc_nbits(enc_nbits),
        .dec_nbits(dec_nbits), .range_err(range_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h (range_in=%h mode=%0d)", tag, act, exp, range_in, dec_mode);
        end
    endtask

    // Behavioural reference
    task automatic model(input bit dec, input logic [15:0] r, input logic [63:0] c,
                         input bit cy, input logic [15:0] st);
        int p;
        int lz;
        int s;
        logic [15:0] nrm;
        logic [63:0] adj;
        logic [15:0] lo_sh;
        logic [15:0] st_sh;
        p = 15;
        while (p >= 0 && r[p] == 1'b0) p--;
        lz = 15 - p;
        e_err = (r == 16'h0000) || (r >= 16'hC000);
        s = 0;
        if (!e_err) begin
            nrm = r << lz;
            s = nrm[14] ? lz - 1 : lz;
        end
        e_shift = 5'(s);
        e_range = e_err ? r : (r << s);
        if (!dec) begin
            adj    = c + ((cy && !e_err) ? 64'h1_0000 : 64'h0);
            e_code = adj << s;
            e_bits = (s == 0) ? 16'h0 : 16'(adj >> (64 - s));
            e_en   = 5'(s);
            e_dn   = 5'd0;
        end else begin
            lo_sh  = c[15:0] << s;
            st_sh  = (s == 0) ? 16'h0 : (st >> (16 - s));
            e_code = {48'h0, lo_sh | st_sh};
            e_bits = 16'h0;
            e_en   = 5'd0;
            e_dn   = 5'(s);
        end
    endtask

    task automatic send(input bit dec, input logic [15:0] r, input logic [63:0] c,
                        input bit cy, input logic [15:0] st);
        @(negedge clk);
        in_valid = 1'b1; dec_mode = dec; range_in = r; code_in = c; carry_in = cy; stream_in = st;
        model(dec, r, c, cy, st);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 out_valid", 64'(out_valid), 64'd1);
        chk("R4 range_out", 64'(range_out), 64'(e_range));
        chk("R4 shift_cnt", 64'(shift_cnt), 64'(e_shift));
        chk("R8 range_err", 64'(range_err), 64'(e_err));
        if (!dec) begin
            chk("R5 enc code_out", code_out, e_code);
            chk("R6 enc_bits", 64'(enc_bits), 64'(e_bits));
            chk("R6 enc_nbits", 64'(enc_nbits), 64'(e_en));
        end else begin
            chk("R7 dec code_out", code_out, e_code);
            chk("R7 dec_nbits", 64'(dec_nbits), 64'(e_dn));
            chk("R7 dec enc_bits", 64'(enc_bits), 64'd0);
        end
        if (!e_err)
            chk("R3 window", 64'(range_out >= 16'h6000 && range_out < 16'hC000), 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rr;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 range_out", 64'(range_out), 64'd0);
        chk("R1 code_out", code_out, 64'd0);
        chk("R1 shift_cnt", 64'(shift_cnt), 64'd0);
        chk("R1 counts", 64'({enc_bits, enc_nbits, dec_nbits, range_err}), 64'd0);
        rst_n = 1'b1;

        // R4 sweep: every leading-one position, bit below clear and set
        for (int k = 0; k < 16; k++) begin
            for (int m = 0; m < 2; m++) begin
                rr = (m == 0 || k == 0) ? (16'h1 << k) : (16'h3 << (k - 1));
                send(1'b0, rr, {$urandom, $urandom}, 1'b0, 16'($urandom));
                send(1'b1, rr, {$urandom, $urandom}, 1'b1, 16'($urandom));
            end
        end

        // R3 window edges
        send(1'b0, 16'h6000, 64'h0123_4567_89AB_CDEF, 1'b0, 16'h0);
        send(1'b0, 16'hBFFF, 64'h0123_4567_89AB_CDEF, 1'b1, 16'h0);
        send(1'b0, 16'h5FFF, 64'hF000_0000_0000_8001, 1'b0, 16'h0);
        send(1'b1, 16'h0001, 64'h0000_0000_0000_ABCD, 1'b0, 16'hFFFE);
        send(1'b1, 16'h0003, 64'h0000_0000_0000_1234, 1'b0, 16'h8421);

        // R5 guard wrap with carry
        send(1'b0, 16'h0100, 64'hFFFF_FFFF_FFFF_5A5A, 1'b1, 16'h0);
        send(1'b0, 16'h8000, 64'h0000_0000_FFFF_FFFF, 1'b1, 16'h0);

        // R8 illegal ranges in both modes
        send(1'b0, 16'h0000, 64'h1111_2222_3333_4444, 1'b1, 16'hFFFF);
        send(1'b0, 16'hC000, 64'h1111_2222_3333_4444, 1'b1, 16'hFFFF);
        send(1'b1, 16'hFFFF, 64'h1111_2222_3333_4444, 1'b1, 16'hFFFF);

        // R2 idle cycles with changing inputs leave outputs alone
        send(1'b0, 16'h0234, 64'h0000_0001_0000_7777, 1'b1, 16'h0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            dec_mode = i[0]; range_in = 16'($urandom); code_in = {$urandom, $urandom};
            carry_in = 1'b1; stream_in = 16'($urandom);
            @(negedge clk);
            chk("R2 idle out_valid", 64'(out_valid), 64'd0);
            chk("R2 idle range_out", 64'(range_out), 64'(e_range));
            chk("R2 idle code_out", code_out, e_code);
            chk("R2 idle shift_cnt", 64'(shift_cnt), 64'(e_shift));
        end

        // Random traffic in both modes
        for (int i = 0; i < 400; i++)
            send(i[0], 16'($urandom), {$urandom, $urandom}, $urandom % 2 == 1, 16'($urandom));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule